// File: doc/BRIEF.md
# Host Command Port Bank Controller

This controller sits between a host I/O processor and a memory subsystem. Outside kernel mode it holds a port control setting and a working register that the normal datapath may write. When kernel mode is entered it saves both, switches the port control to input mode, issues a burst of refresh strobes and then polls a command port. Every command byte is decoded by its two low bits into one of four actions: leave kernel mode (restoring both saved values), issue an extra refresh, load the memory bank register, or answer a liveness probe with a fixed code.

Refresh is never starved. The poll loop advances the working register once per poll cycle, and each time its low nibble carries out a three-strobe burst is issued. Every command ends in that same burst. The set-bank command waits a settling period and then polls for a second byte that carries the bank number, with a refresh strobe in every pass of that wait loop. The new bank value is echoed back to the host.

The command port is a valid/ready stream. A byte is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only in the poll cycle and in the set-bank check cycle, so the host may hold `req_valid` and `req_data` for as long as it needs to. The response port has no back-pressure: `rsp_valid` is a one-cycle pulse and the host must capture `rsp_data` in that cycle. `rsp_data` then holds its value until the next response.

Top module: `hcb_top`

## Requirements
- R1: A synchronous active-high reset drives `refresh`, `req_ready`, `rsp_valid`, `rsp_data`, `bank`, `port_ctl` and `work` to zero and leaves the controller outside kernel mode.
- R2: Outside kernel mode, `ext_we` loads `ext_ctl` into `port_ctl` and `ext_work` into `work` on the next edge. `req_ready` stays low, so a pending `req_valid` is neither accepted nor answered.
- R3: `kern_enter` outside kernel mode saves `port_ctl` and `work` and sets `port_ctl` to input mode (value 1) on the next edge. `refresh` is then high for exactly 3 cycles, after which polling begins with `req_ready` high.
- R4: Each poll cycle without an accepted byte increments `work`. In a poll cycle where `work[3:0]` is 4'b1111, a 3-cycle refresh burst follows. From a starting low nibble n, there are 16-n poll cycles before the first burst.
- R5: An accepted byte is decoded by `req_data[1:0]` only (00 exit, 01 extra refresh, 10 set bank, 11 probe); bits 7:2 have no effect.
- R6: Command 00 restores the saved `port_ctl` and `work` on the accept edge and returns to outside kernel mode. `ext_we` pulses that arrive while in kernel mode are ignored.
- R7: Command 01 gives 4 consecutive refresh cycles (one extra plus the 3-cycle burst), then polling resumes.
- R8: Command 11 produces a single-cycle `rsp_valid` with `rsp_data` = 8'h07 in the cycle after acceptance, followed by the 3-cycle refresh burst.
- R9: After command 10, the controller runs a 4-cycle wait loop. `refresh` is high in the first cycle, the next two cycles are quiet, and `req_ready` is high in the fourth. The loop repeats until a byte arrives, and `bank` does not change while it waits.
- R10: The byte accepted in the set-bank check cycle is loaded into `bank` and echoed as a single-cycle `rsp_valid` with `rsp_data` equal to that byte. The 3-cycle refresh burst follows.
- R11: `bank` changes only as a result of a completed set-bank sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kern_enter | input | 1 | Request to enter kernel mode |
| ext_we | input | 1 | Normal-side write of port control and working register |
| ext_ctl | input | 2 | Port control value for `ext_we` |
| ext_work | input | 8 | Working register value for `ext_we` |
| req_valid | input | 1 | Command port byte valid |
| req_ready | output | 1 | Controller accepts a command port byte |
| req_data | input | 8 | Command port byte |
| rsp_valid | output | 1 | Response byte pulse |
| rsp_data | output | 8 | Response byte |
| refresh | output | 1 | Memory refresh strobe |
| bank | output | 8 | Memory bank register |
| port_ctl | output | 2 | Port control setting |
| work | output | 8 | Working register / poll counter |

## Verification
Every register in the block updates on the same edge that accepts a byte or takes `kern_enter`, and `req_ready`/`refresh` decode the state directly. A result that follows an edge is therefore visible at the falling edge right after it. The bench drives inputs and samples outputs only on falling edges. It counts cycle positions from the falling edge after the accept edge: position 1 carries a response pulse or restored value, positions 1–4 cover the extra-refresh run, and positions 1, 4 and 5 cover the wait loop's refresh, ready and retry. The poll period is swept over all 16 starting nibbles and compared with 16-n, counted from the first poll cycle to the first refresh.

// File: rtl/hcb_pkg.sv
package hcb_pkg;
  typedef enum logic [2:0] {
    S_OUT,
    S_BURST,
    S_XREF,
    S_WAIT,
    S_WCHK,
    S_POLL
  } hcb_state_e;

  localparam logic [1:0] CMD_EXIT  = 2'd0;
  localparam logic [1:0] CMD_XREF  = 2'd1;
  localparam logic [1:0] CMD_BANK  = 2'd2;
  localparam logic [1:0] CMD_PROBE = 2'd3;

  localparam logic [7:0] PROBE_CODE = 8'h07;
endpackage

// File: rtl/hcb_ctx.sv
module hcb_ctx #(
  parameter int CTL_W = 2,
  parameter int WORK_W = 8,
  parameter logic [CTL_W-1:0] IN_MODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_kernel,
  input  logic              ev_enter,
  input  logic              ev_exit,
  input  logic              poll_tick,
  input  logic              ext_we,
  input  logic [CTL_W-1:0]  ext_ctl,
  input  logic [WORK_W-1:0] ext_work,
  output logic [CTL_W-1:0]  port_ctl,
  output logic [WORK_W-1:0] work,
  output logic              nib_carry
);
  logic [CTL_W-1:0]  save_ctl;
  logic [WORK_W-1:0] save_work;

  assign nib_carry = (work[3:0] == 4'hF);

  always_ff @(posedge clk) begin
    if (rst) begin
      port_ctl  <= '0;
      work      <= '0;
      save_ctl  <= '0;
      save_work <= '0;
    end else if (ev_enter) begin
      save_ctl  <= port_ctl;
      save_work <= work;
      port_ctl  <= IN_MODE;
    end else if (ev_exit) begin
      port_ctl <= save_ctl;
      work     <= save_work;
    end else if (!in_kernel && ext_we) begin
      port_ctl <= ext_ctl;
      work     <= ext_work;
    end else if (poll_tick) begin
      work <= work + WORK_W'(1);
    end
  end

  // R3: kernel entry switches the port to input mode
  assert_enter_inmode_R3: assert property (@(posedge clk) disable iff (rst)
    ev_enter |=> (port_ctl == IN_MODE));

  // R6: exit brings back both saved values
  assert_exit_restore_R6: assert property (@(posedge clk) disable iff (rst)
    ev_exit |=> (port_ctl == $past(save_ctl) && work == $past(save_work)));
endmodule

// File: rtl/hcb_seq.sv
module hcb_seq
  import hcb_pkg::*;
#(
  parameter int BURST_LEN = 3,
  parameter int WAIT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       kern_enter,
  input  logic       req_valid,
  input  logic [1:0] cmd,
  input  logic       nib_carry,
  output logic       req_ready,
  output logic       refresh,
  output logic       in_kernel,
  output logic       ev_enter,
  output logic       ev_exit,
  output logic       ev_probe,
  output logic       ev_bank,
  output logic       poll_tick
);
  localparam int BCW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int WCW = (WAIT_LEN > 1) ? $clog2(WAIT_LEN) : 1;

  hcb_state_e st;
  logic [BCW-1:0] bcnt;
  logic [WCW-1:0] wcnt;
  logic take;

  assign req_ready = (st == S_POLL) || (st == S_WCHK);
  assign refresh   = (st == S_BURST) || (st == S_XREF) ||
                     ((st == S_WAIT) && (wcnt == '0));
  assign take      = req_valid && req_ready;
  assign in_kernel = (st != S_OUT);
  assign poll_tick = (st == S_POLL);
  assign ev_enter  = (st == S_OUT) && kern_enter;
  assign ev_exit   = (st == S_POLL) && take && (cmd == CMD_EXIT);
  assign ev_probe  = (st == S_POLL) && take && (cmd == CMD_PROBE);
  assign ev_bank   = (st == S_WCHK) && take;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_OUT;
      bcnt <= '0;
      wcnt <= '0;
    end else begin
      case (st)
        S_OUT: if (kern_enter) begin
          st   <= S_BURST;
          bcnt <= '0;
        end
        S_BURST: begin
          if (bcnt == BCW'(BURST_LEN - 1)) st <= S_POLL;
          else bcnt <= bcnt + BCW'(1);
        end
        S_XREF: begin
          st   <= S_BURST;
          bcnt <= '0;
        end
        S_WAIT: begin
          if (wcnt == WCW'(WAIT_LEN - 1)) st <= S_WCHK;
          else wcnt <= wcnt + WCW'(1);
        end
        S_WCHK: begin
          if (take) begin
            st   <= S_BURST;
            bcnt <= '0;
          end else begin
            st   <= S_WAIT;
            wcnt <= '0;
          end
        end
        S_POLL: begin
          if (take) begin
            case (cmd)
              CMD_EXIT: st <= S_OUT;
              CMD_XREF: st <= S_XREF;
              CMD_BANK: begin
                st   <= S_WAIT;
                wcnt <= '0;
              end
              default: begin
                st   <= S_BURST;
                bcnt <= '0;
              end
            endcase
          end else if (nib_carry) begin
            st   <= S_BURST;
            bcnt <= '0;
          end
        end
        default: st <= S_OUT;
      endcase
    end
  end

  // R10: a taken bank byte is followed by refresh, not by another accept
  assert_bank_then_burst_R10: assert property (@(posedge clk) disable iff (rst)
    ev_bank |=> (refresh && !req_ready));

  // R9: an idle check cycle loops back into a refreshing wait cycle
  assert_wait_retry_R9: assert property (@(posedge clk) disable iff (rst)
    (st == S_WCHK && !req_valid) |=> (refresh && !req_ready));
endmodule

// File: rtl/hcb_top.sv
module hcb_top
  import hcb_pkg::*;
#(
  parameter int CTL_W = 2,
  parameter int WORK_W = 8,
  parameter int BANK_W = 8,
  parameter int BURST_LEN = 3,
  parameter int WAIT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kern_enter,
  input  logic              ext_we,
  input  logic [CTL_W-1:0]  ext_ctl,
  input  logic [WORK_W-1:0] ext_work,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_data,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              refresh,
  output logic [BANK_W-1:0] bank,
  output logic [CTL_W-1:0]  port_ctl,
  output logic [WORK_W-1:0] work
);
  logic in_kernel, ev_enter, ev_exit, ev_probe, ev_bank, poll_tick, nib_carry;

  hcb_seq #(.BURST_LEN(BURST_LEN), .WAIT_LEN(WAIT_LEN)) u_seq (
    .clk(clk), .rst(rst), .kern_enter(kern_enter), .req_valid(req_valid),
    .cmd(req_data[1:0]), .nib_carry(nib_carry), .req_ready(req_ready),
    .refresh(refresh), .in_kernel(in_kernel), .ev_enter(ev_enter),
    .ev_exit(ev_exit), .ev_probe(ev_probe), .ev_bank(ev_bank),
    .poll_tick(poll_tick)
  );

  hcb_ctx #(.CTL_W(CTL_W), .WORK_W(WORK_W)) u_ctx (
    .clk(clk), .rst(rst), .in_kernel(in_kernel), .ev_enter(ev_enter),
    .ev_exit(ev_exit), .poll_tick(poll_tick), .ext_we(ext_we),
    .ext_ctl(ext_ctl), .ext_work(ext_work), .port_ctl(port_ctl),
    .work(work), .nib_carry(nib_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bank      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= ev_probe || ev_bank;
      if (ev_probe) rsp_data <= PROBE_CODE;
      else if (ev_bank) rsp_data <= req_data;
      if (ev_bank) bank <= req_data[BANK_W-1:0];
    end
  end

  // R8: probe answer follows one cycle after acceptance
  assert_probe_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    ev_probe |=> (rsp_valid && rsp_data == PROBE_CODE));

  // R8: a response is a single-cycle pulse
  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R10: echoed byte equals the new bank
  assert_bank_echo_R10: assert property (@(posedge clk) disable iff (rst)
    ev_bank |=> (rsp_valid && rsp_data[BANK_W-1:0] == bank));

  // R11: bank holds unless a set-bank sequence completes
  assert_bank_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !ev_bank |=> $stable(bank));
endmodule

// File: tb/tb_hcb_top.sv
module tb_hcb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kern_enter = 1'b0;
  logic ext_we = 1'b0;
  logic [1:0] ext_ctl = '0;
  logic [7:0] ext_work = '0;
  logic req_valid = 1'b0;
  logic [7:0] req_data = '0;
  logic req_ready, rsp_valid, refresh;
  logic [7:0] rsp_data, bank, work;
  logic [1:0] port_ctl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hcb_top dut (
    .clk(clk), .rst(rst), .kern_enter(kern_enter), .ext_we(ext_we),
    .ext_ctl(ext_ctl), .ext_work(ext_work), .req_valid(req_valid),
    .req_ready(req_ready), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .refresh(refresh), .bank(bank),
    .port_ctl(port_ctl), .work(work)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    req_valid = 1'b1;
    req_data  = b;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ext_load(input logic [1:0] c, input logic [7:0] w);
    ext_we = 1'b1; ext_ctl = c; ext_work = w;
    @(negedge clk);
    ext_we = 1'b0;
  endtask

  task automatic enter_kernel();
    kern_enter = 1'b1;
    @(negedge clk);
    kern_enter = 1'b0;
  endtask

  task automatic reach_poll();
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev_bank;
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 refresh", refresh, 0);
    chk("R1 req_ready", req_ready, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 rsp_data", rsp_data, 0);
    chk("R1 bank", bank, 0);
    chk("R1 port_ctl", port_ctl, 0);
    chk("R1 work", work, 0);

    // R2 normal-side write and no acceptance outside kernel
    ext_load(2'b10, 8'h35);
    chk("R2 port_ctl", port_ctl, 2'b10);
    chk("R2 work", work, 8'h35);
    req_valid = 1'b1; req_data = 8'h03;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 ready low", req_ready, 0);
      chk("R2 no rsp", rsp_valid, 0);
    end
    req_valid = 1'b0;

    // R3 entry
    enter_kernel();
    chk("R3 in mode", port_ctl, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R3 burst refresh", refresh, 1);
      chk("R3 burst no ready", req_ready, 0);
      @(negedge clk);
    end
    chk("R3 poll refresh", refresh, 0);
    chk("R3 poll ready", req_ready, 1);

    // R6 and R5: exit with upper bits set
    send(8'hFC);
    chk("R6 restore ctl", port_ctl, 2'b10);
    chk("R6 restore work", work, 8'h35);
    chk("R6 outside ready", req_ready, 0);
    chk("R6 outside refresh", refresh, 0);

    // R4 poll period sweep over all starting nibbles, with R6 restore
    for (int n = 0; n < 16; n++) begin
      logic [7:0] w;
      logic [1:0] c;
      w = 8'((n << 4) | n);
      c = 2'(n);
      ext_load(c, w);
      enter_kernel();
      while (refresh) @(negedge clk);
      cnt = 0;
      while (!refresh && cnt < 40) begin
        if (!req_ready) cnt = 100;
        cnt++;
        @(negedge clk);
      end
      chk("R4 poll count", cnt, 16 - n);
      ext_load(~c, ~w);
      reach_poll();
      send(8'h00);
      chk("R6 sweep ctl", port_ctl, c);
      chk("R6 sweep work", work, w);
    end

    // R7 extra refresh (R5: 0x5D decodes as 01)
    ext_load(2'b00, 8'h00);
    enter_kernel();
    reach_poll();
    send(8'h5D);
    for (int i = 1; i <= 4; i++) begin
      chk("R7 refresh run", refresh, 1);
      @(negedge clk);
    end
    chk("R7 run ends", refresh, 0);
    chk("R7 poll again", req_ready, 1);

    // R8 probe, with and without upper bits
    for (int k = 0; k < 2; k++) begin
      reach_poll();
      send(k == 0 ? 8'h03 : 8'hFF);
      chk("R8 rsp_valid", rsp_valid, 1);
      chk("R8 rsp_data", rsp_data, 8'h07);
      chk("R8 burst", refresh, 1);
      @(negedge clk);
      chk("R8 pulse", rsp_valid, 0);
    end

    // R9 / R10 / R11 set-bank sweep
    prev_bank = 8'h00;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = 8'(i * 37 + 1);
      if (i == 7) v = 8'hFF;
      reach_poll();
      send(8'((i << 2) | 2));
      chk("R9 wait refresh", refresh, 1);
      chk("R9 wait not ready", req_ready, 0);
      @(negedge clk);
      chk("R9 quiet1", refresh | req_ready, 0);
      @(negedge clk);
      chk("R9 quiet2", refresh | req_ready, 0);
      @(negedge clk);
      chk("R9 check ready", req_ready, 1);
      chk("R9 check no refresh", refresh, 0);
      @(negedge clk);
      chk("R9 retry refresh", refresh, 1);
      chk("R11 bank held", bank, prev_bank);
      send(v);
      chk("R10 bank", bank, v);
      chk("R10 echo valid", rsp_valid, 1);
      chk("R10 echo data", rsp_data, v);
      chk("R10 burst", refresh, 1);
      @(negedge clk);
      chk("R10 pulse", rsp_valid, 0);
      prev_bank = v;
    end

    // R11: other commands leave bank alone
    reach_poll();
    send(8'h03);
    reach_poll();
    send(8'h01);
    reach_poll();
    chk("R11 bank after other cmds", bank, prev_bank);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule